// File: doc/BRIEF.md
# One-Shot Pulse Timer with Fast Enable

This block produces a single pulse after a trigger. It watches one trigger input for an edge of the chosen direction. When that edge is seen and the timer is idle, it starts a counter from zero. While the counter runs, a reference level is built from the count and a compare value, in one of four channel modes. When the count reaches the auto-reload value, the counter stops and returns to zero. The reference then goes back to its idle level, so each qualified trigger gives exactly one shot.

Without fast enable, the compare-driven reference trails the counter by one register. The first level change therefore comes some cycles after the trigger. In the two PWM modes, setting fast enable removes that delay. The reference is forced, on the same clock edge that sees the trigger, to the level a compare match would give, and it holds that level for the rest of the shot without looking at the compare result. A polarity bit sets how the reference maps to the pin. The running flag shows when a shot is in progress.

All pins are plain control and status signals with no handshake. The compare value, auto-reload value, mode, fast-enable bit and polarity must be held stable while a shot runs, and are changed only while the running flag is low.

Top module: `opm_timer`

## Requirements
- R1: After reset the running flag is 0, the reference is 0 and the pulse pin equals the polarity bit.
- R2: With the edge-select bit at 0 a 0-to-1 change of the trigger starts a shot, and with it at 1 a 1-to-0 change does; the running flag is 1 after the clock edge that first samples the new trigger level, and the opposite change never starts a shot.
- R3: A shot counts 0, 1, ..., auto-reload, keeping the running flag high for auto-reload + 1 cycles. After that the flag and the reference are both 0.
- R4: In mode 2'b10 (PWM mode 2), the reference is 1 for counts at or above the compare value, and the level for count c shows after clock edge T+1+c, where T is the edge that saw the trigger.
- R5: In mode 2'b01 (PWM mode 1) the reference is 1 for counts below the compare value, with the same one-cycle lag as R4.
- R6: In mode 2'b11 (toggle) the reference starts each shot at 0 and inverts when the count equals the compare value, with the same lag as R4.
- R7: In mode 2'b00 (frozen) the reference stays 0 for the whole shot.
- R8: With fast enable set in mode 2'b10 the reference is 1 right after edge T and stays 1 to the end of the shot; with fast enable set in mode 2'b01 it stays 0 for the whole shot.
- R9: In modes 2'b00 and 2'b11 the fast-enable bit has no effect on the reference.
- R10: Trigger edges that arrive while a shot runs are ignored: the count and the reference go on as if no such edge had come.
- R11: The pulse pin equals the reference XOR the polarity bit.
- R12: A qualified trigger that comes after a shot has ended starts a new shot that behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger input |
| edge_fall_i | input | 1 | Edge select: 0 rising, 1 falling |
| mode_i | input | 2 | Channel mode: 00 frozen, 01 PWM1, 10 PWM2, 11 toggle |
| fast_en_i | input | 1 | Fast enable (PWM modes only) |
| pol_i | input | 1 | Output polarity: 1 inverts the reference at the pin |
| cmp_i | input | CNT_W | Compare value |
| arr_i | input | CNT_W | Auto-reload (last count) value |
| pulse_o | output | 1 | Pulse output pin |
| ref_o | output | 1 | Internal reference level |
| running_o | output | 1 | High while a shot is counting |

## Verification
Let T be the clock edge that samples the trigger change. The running flag and any fast-enabled reference change are due just after edge T. The compare-driven level for count c is due after edge T+1+c. The return to idle is due after edge T+auto-reload+1. The bench applies every stimulus and reads every result at the falling clock edge. For each shot it walks the cycles after T one at a time and compares each sampled value with the value its own cycle model predicts for that cycle. Retriggers are placed in the middle of a shot, so that any reaction they caused would show up in the cycles the bench samples next.

// File: rtl/opm_pkg.sv
package opm_pkg;

  typedef enum logic [1:0] {
    MODE_FROZEN = 2'b00,
    MODE_PWM1   = 2'b01,
    MODE_PWM2   = 2'b10,
    MODE_TOGGLE = 2'b11
  } opm_mode_e;

  // fast enable is honoured only in the two PWM modes
  function automatic logic fast_allowed(opm_mode_e m);
    return (m == MODE_PWM1) || (m == MODE_PWM2);
  endfunction

  // level a compare match leaves the reference at
  function automatic logic match_level(opm_mode_e m);
    return (m == MODE_PWM2);
  endfunction

endpackage

// File: rtl/opm_edge_det.sv
module opm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic fall_sel_i,
  input  logic armed_i,
  output logic start_o
);

  logic trig_q;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign rise_w  = trig_i & ~trig_q;
  assign fall_w  = ~trig_i & trig_q;
  assign start_o = armed_i & (fall_sel_i ? fall_w : rise_w);

endmodule

// File: rtl/opm_counter.sv
module opm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign last_o = run_q && (cnt_q == arr_i);
  assign cnt_o  = cnt_q;
  assign run_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (last_o) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R3
  stop_at_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (!run_q && cnt_q == '0));

  // R3
  count_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= arr_i));

  // R10
  retrig_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !last_o) |=> (run_q && cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/opm_channel.sv
module opm_channel #(
  parameter int CNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                run_i,
  input  logic                last_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [CNT_W-1:0]    cmp_i,
  input  opm_pkg::opm_mode_e  mode_i,
  input  logic                fast_en_i,
  output logic                ref_o
);

  import opm_pkg::*;

  logic ref_q;
  logic fast_run_q;
  logic fast_now;
  logic cmp_level;

  assign fast_now = start_i & fast_en_i & fast_allowed(mode_i);

  always_comb begin
    unique case (mode_i)
      MODE_FROZEN: cmp_level = 1'b0;
      MODE_PWM1:   cmp_level = (cnt_i < cmp_i);
      MODE_PWM2:   cmp_level = (cnt_i >= cmp_i);
      MODE_TOGGLE: cmp_level = (cnt_i == cmp_i) ? ~ref_q : ref_q;
      default:     cmp_level = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q      <= 1'b0;
      fast_run_q <= 1'b0;
    end else if (start_i) begin
      fast_run_q <= fast_now;
      ref_q      <= fast_now ? match_level(mode_i) : 1'b0;
    end else if (run_i && !last_i) begin
      ref_q <= fast_run_q ? match_level(mode_i) : cmp_level;
    end else begin
      ref_q      <= 1'b0;
      fast_run_q <= 1'b0;
    end
  end

  assign ref_o = ref_q;

  // R8
  fast_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_now |=> (ref_q == match_level($past(mode_i))));

  // R7
  frozen_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FROZEN) |=> !ref_q);

  // R3
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> !ref_q);

endmodule

// File: rtl/opm_timer.sv
module opm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             edge_fall_i,
  input  logic [1:0]       mode_i,
  input  logic             fast_en_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic             pulse_o,
  output logic             ref_o,
  output logic             running_o
);

  opm_pkg::opm_mode_e mode_e;
  logic               start_w;
  logic               run_w;
  logic               last_w;
  logic [CNT_W-1:0]   cnt_w;
  logic               ref_w;

  assign mode_e = opm_pkg::opm_mode_e'(mode_i);

  opm_edge_det u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .fall_sel_i (edge_fall_i),
    .armed_i    (~run_w),
    .start_o    (start_w)
  );

  opm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .arr_i   (arr_i),
    .cnt_o   (cnt_w),
    .run_o   (run_w),
    .last_o  (last_w)
  );

  opm_channel #(.CNT_W(CNT_W)) u_chan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .run_i     (run_w),
    .last_i    (last_w),
    .cnt_i     (cnt_w),
    .cmp_i     (cmp_i),
    .mode_i    (mode_e),
    .fast_en_i (fast_en_i),
    .ref_o     (ref_w)
  );

  assign ref_o     = ref_w;
  assign running_o = run_w;
  assign pulse_o   = ref_w ^ pol_i;

  // R2
  start_sets_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> running_o);

endmodule

// File: tb/test_opm_timer.sv
module test_opm_timer;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic          fall = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          fe = 1'b0;
  logic          pol = 1'b0;
  logic [CW-1:0] cmp = '0;
  logic [CW-1:0] arr = '0;
  logic          pulse, refl, running;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opm_timer #(.CNT_W(CW)) i_opm_timer (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .edge_fall_i(fall),
    .mode_i(mode), .fast_en_i(fe), .pol_i(pol), .cmp_i(cmp), .arr_i(arr),
    .pulse_o(pulse), .ref_o(refl), .running_o(running)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // one shot: configure while idle, fire, then compare every cycle to the model
  task automatic shot(string req, logic [1:0] m, int c, int a, bit f,
                      bit p, bit fl, bit retrig);
    bit idle_lvl, fast_run, lvl, tog, er, eref;
    @(negedge clk);
    mode = m; cmp = CW'(c); arr = CW'(a); fe = f; pol = p; fall = fl;
    idle_lvl = fl;
    trig = idle_lvl;
    repeat (2) @(negedge clk);
    check(req, "idle running", running, 1'b0);
    check("R11", "idle pulse", pulse, p);
    trig = ~idle_lvl;
    fast_run = f && (m == 2'b01 || m == 2'b10);
    lvl = (m == 2'b10);
    tog = 1'b0;
    for (int j = 0; j <= a + 1; j++) begin
      @(negedge clk);
      er = (j <= a);
      if (j == 0) eref = fast_run ? lvl : 1'b0;
      else if (j <= a) begin
        if (fast_run) eref = lvl;
        else begin
          case (m)
            2'b00: eref = 1'b0;
            2'b01: eref = ((j - 1) < c);
            2'b10: eref = ((j - 1) >= c);
            default: begin
              if ((j - 1) == c) tog = ~tog;
              eref = tog;
            end
          endcase
        end
      end else eref = 1'b0;
      check(req, $sformatf("running j=%0d", j), running, er);
      check(req, $sformatf("ref j=%0d", j), refl, eref);
      check("R11", $sformatf("pulse j=%0d", j), pulse, eref ^ p);
      if (retrig && j == 1) trig = idle_lvl;
      if (retrig && j == 2) trig = ~idle_lvl;
    end
    trig = idle_lvl;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "reset running", running, 1'b0);
    check("R1", "reset ref", refl, 1'b0);
    check("R1", "reset pulse", pulse, pol);
  endtask

  task automatic t_pwm2();
    shot("R4", 2'b10, 3, 7, 0, 0, 0, 0);
    shot("R4", 2'b10, 0, 4, 0, 0, 0, 0);
    shot("R4", 2'b10, 9, 5, 0, 0, 0, 0);
    shot("R3", 2'b10, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pwm1();
    shot("R5", 2'b01, 4, 6, 0, 0, 0, 0);
    shot("R5", 2'b01, 0, 3, 0, 1, 0, 0);
  endtask

  task automatic t_toggle();
    shot("R6", 2'b11, 2, 6, 0, 0, 0, 0);
  endtask

  task automatic t_frozen();
    shot("R7", 2'b00, 1, 5, 0, 0, 0, 0);
  endtask

  task automatic t_fast();
    shot("R8", 2'b10, 5, 8, 1, 0, 0, 0);
    shot("R8", 2'b01, 3, 6, 1, 0, 0, 0);
  endtask

  task automatic t_fast_ignored();
    shot("R9", 2'b11, 2, 6, 1, 0, 0, 0);
    shot("R9", 2'b00, 2, 4, 1, 1, 0, 0);
  endtask

  task automatic t_falling();
    shot("R2", 2'b10, 2, 5, 0, 1, 1, 0);
    // opposite direction must not start a shot
    @(negedge clk); fall = 1'b0; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (2) @(negedge clk);
    check("R2", "falling edge with rising select", running, 1'b0);
  endtask

  task automatic t_retrigger();
    shot("R10", 2'b10, 4, 8, 0, 0, 0, 1);
  endtask

  task automatic t_restart();
    shot("R12", 2'b10, 1, 3, 0, 0, 0, 0);
    shot("R12", 2'b10, 1, 3, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pwm2();
    t_pwm1();
    t_toggle();
    t_frozen();
    t_fast();
    t_fast_ignored();
    t_falling();
    t_retrigger();
    t_restart();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule